// File: doc/BRIEF.md
# Single-Descriptor Flash Page DMA Engine

This engine moves one buffer of flash data between system memory and the byte streams of a flash data path. Before a transfer, software leaves a four-word buffer descriptor in memory and gives the engine its address on `desc_base_i`. The four words are status, sizes, buffer pointer 0 and buffer pointer 1. A one-cycle `start_i` pulse then launches a transfer. `dir_i` chooses memory-to-flash (0) or flash-to-memory (1), and `len_i` gives the byte count of the flash command.

The engine first fetches the descriptor and tests its ownership flag. If software has not handed the descriptor over, the engine raises a descriptor-unavailable pulse and stops there. Otherwise, in the memory-to-flash direction, it reads 64-bit beats from the buffer and serialises them onto the transmit byte stream. In the other direction it packs received bytes into 64-bit beats and writes them to the buffer. At the end it writes the status word back with ownership returned to software. It then pulses the completion flag for the direction it ran.

The memory side is a request/grant port with a separate read-data strobe, and only one access is outstanding at a time. Both byte streams use valid/ready handshakes.

Top module: `nand_dma_engine`

## Requirements
- R1: While reset is asserted and after reset, `mem_req_o`, `tx_valid_o`, `rx_ready_o`, `tx_done_o`, `rx_done_o` and `desc_unavail_o` are all 0.
- R2: A start in idle reads the 64-bit word at `desc_base_i` first. Its bits [31:0] are the status word and bits [63:32] are the sizes word, with the buffer size in sizes bits [11:0]. The engine then reads `desc_base_i`+8, whose bits [31:0] are buffer pointer 0; bits [63:32] (buffer pointer 1) are ignored.
- R3: If status bit 31 (ownership) is 0, the engine pulses `desc_unavail_o` for one cycle. It makes no further memory access, sends no transmit byte and leaves the descriptor in memory unchanged.
- R4: For `dir_i`=0 and length N, the engine reads ceil(N/8) beats at pointer 0, pointer 0+8, and so on, in increasing order. It sends exactly N bytes on the transmit stream. Within a beat, byte k is taken from bits [8k+7:8k], lowest k first, and the padding bytes of the last beat are not sent.
- R5: For `dir_i`=1 and length N, the engine accepts exactly N bytes and writes ceil(N/8) beats at pointer 0, pointer 0+8, and so on. Byte k of a beat goes to bits [8k+7:8k], and the unfilled bytes of the last beat are written as zero.
- R6: After the data phase, the engine writes the word at `desc_base_i` back as {sizes, status with bit 31 cleared}; all other bits are unchanged. The completion pulse comes in the cycle after this write is granted, once all data accesses and stream bytes are done.
- R7: A memory-to-flash transfer ends with a one-cycle `tx_done_o` pulse and a flash-to-memory transfer with a one-cycle `rx_done_o` pulse. At most one of `tx_done_o`, `rx_done_o` and `desc_unavail_o` is high in any cycle.
- R8: A memory request that is not granted keeps its address, write enable and write data unchanged in the next cycle. A transmit byte that is not accepted stays valid and unchanged.
- R9: `start_i` during a transfer is ignored. A `start_i` in the same cycle as a completion pulse starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch one transfer (accepted when idle) |
| dir_i | input | 1 | 0 = memory to flash, 1 = flash to memory |
| len_i | input | LEN_W | Byte count of the flash command |
| desc_base_i | input | ADDR_W | Byte address of the descriptor |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | 8-byte aligned byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data strobe |
| mem_rdata_i | input | 64 | Read data |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmit byte accepted |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Engine takes the receive byte |
| tx_done_o | output | 1 | Memory-to-flash transfer complete pulse |
| rx_done_o | output | 1 | Flash-to-memory transfer complete pulse |
| desc_unavail_o | output | 1 | Descriptor not owned by the engine pulse |

## Verification
A completion pulse and the acceptance of a new start can fall in the same cycle. The engine is already idle when it raises the pulse, so a start seen in that cycle begins the next descriptor fetch at once. The bench provokes this by watching for the pulse of a flash-to-memory transfer and raising `start_i` in that same cycle for a queued memory-to-flash transfer. It judges the result by the scoreboard, which expects the second transfer's descriptor read as the very next memory access and expects its transmit bytes to follow. In a separate run, starts repeated during a transfer must leave the access sequence exactly as expected.

// File: rtl/nand_dma_pkg.sv
package nand_dma_pkg;
   localparam int OWN_BIT   = 31;
   localparam int FIRST_BIT = 3;
   localparam int LAST_BIT  = 2;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DSC0_REQ,
      S_DSC0_WAIT,
      S_DSC1_REQ,
      S_DSC1_WAIT,
      S_TX_REQ,
      S_TX_WAIT,
      S_TX_DRAIN,
      S_RX_FILL,
      S_RX_PUT,
      S_WB_REQ
   } dma_state_e;
endpackage

// File: rtl/nand_dma_txser.sv
module nand_dma_txser #(
   parameter int BEAT_BYTES = 8,
   localparam int DATA_W = 8 * BEAT_BYTES,
   localparam int CNT_W  = $clog2(BEAT_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] beat_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              empty_o,
   output logic              tx_valid_o,
   output logic [7:0]        tx_data_o,
   input  logic              tx_ready_i
);
   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
      end else if (load_i) begin
         shreg_q <= beat_i;
         left_q  <= cnt_i;
      end else if (tx_valid_o && tx_ready_i) begin
         shreg_q <= shreg_q >> 8;
         left_q  <= left_q - CNT_W'(1);
      end
   end

   assign tx_valid_o = (left_q != '0);
   assign tx_data_o  = shreg_q[7:0];
   assign empty_o    = (left_q == '0);

   // R8: an unaccepted byte is held
   assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

   // R4: the controller only loads a new beat after the previous one drained
   assert_load_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (empty_o && cnt_i != '0));
endmodule

// File: rtl/nand_dma_rxpack.sv
module nand_dma_rxpack #(
   parameter int BEAT_BYTES = 8,
   localparam int DATA_W = 8 * BEAT_BYTES,
   localparam int CNT_W  = $clog2(BEAT_BYTES + 1),
   localparam int LANE_W = $clog2(BEAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              full_o,
   output logic [DATA_W-1:0] beat_o,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_data_i,
   output logic              rx_ready_o
);
   logic [LANE_W-1:0] idx_q;
   logic [CNT_W-1:0]  left_q;
   logic              take;

   assign take       = rx_valid_i && rx_ready_o;
   assign rx_ready_o = (left_q != '0);
   assign full_o     = (left_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         left_q <= '0;
      end else if (arm_i) begin
         idx_q  <= '0;
         left_q <= cnt_i;
      end else if (take) begin
         idx_q  <= idx_q + LANE_W'(1);
         left_q <= left_q - CNT_W'(1);
      end
   end

   for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_lane
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
         if (!rst_n || arm_i) begin
            byte_q <= '0;
         end else if (take && idx_q == LANE_W'(k)) begin
            byte_q <= rx_data_i;
         end
      end
      assign beat_o[8*k +: 8] = byte_q;
   end

   // R5: every armed beat asks for between one and a full beat of bytes
   assert_arm_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |-> (cnt_i != '0 && cnt_i <= CNT_W'(BEAT_BYTES) && full_o));
endmodule

// File: rtl/nand_dma_ctrl.sv
module nand_dma_ctrl
   import nand_dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 12,
   parameter int BEAT_BYTES = 8,
   localparam int DATA_W = 8 * BEAT_BYTES,
   localparam int CNT_W  = $clog2(BEAT_BYTES + 1),
   localparam int OFF_W  = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] desc_base_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              ser_load_o,
   output logic [CNT_W-1:0]  ser_cnt_o,
   input  logic              ser_empty_i,
   output logic              pk_arm_o,
   output logic [CNT_W-1:0]  pk_cnt_o,
   input  logic              pk_full_i,
   input  logic [DATA_W-1:0] pk_beat_i,
   output logic              tx_done_o,
   output logic              rx_done_o,
   output logic              desc_unavail_o
);
   dma_state_e        state_q;
   logic              dir_q;
   logic [LEN_W-1:0]  rem_q;
   logic [OFF_W-1:0]  off_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [31:0]       status_q;
   logic [31:0]       sizes_q;

   logic [CNT_W-1:0]  cur_cnt;
   logic [CNT_W-1:0]  next_cnt;
   logic [LEN_W-1:0]  rem_after;
   logic [31:0]       status_ret;

   assign cur_cnt    = (rem_q >= LEN_W'(BEAT_BYTES)) ? CNT_W'(BEAT_BYTES) : rem_q[CNT_W-1:0];
   assign rem_after  = rem_q - LEN_W'(cur_cnt);
   assign next_cnt   = (rem_after >= LEN_W'(BEAT_BYTES)) ? CNT_W'(BEAT_BYTES) : rem_after[CNT_W-1:0];
   assign status_ret = status_q & ~(32'h1 << OWN_BIT);

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      unique case (state_q)
         S_DSC0_REQ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = base_q;
         end
         S_DSC1_REQ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = base_q + ADDR_W'(BEAT_BYTES);
         end
         S_TX_REQ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = ptr_q + ADDR_W'(off_q);
         end
         S_RX_PUT: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = ptr_q + ADDR_W'(off_q);
            mem_wdata_o = pk_beat_i;
         end
         S_WB_REQ: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = base_q;
            mem_wdata_o = {sizes_q, status_ret};
         end
         default: ;
      endcase
   end

   assign ser_load_o = (state_q == S_TX_WAIT) && mem_rvalid_i;
   assign ser_cnt_o  = cur_cnt;
   assign pk_arm_o   = ((state_q == S_DSC1_WAIT) && mem_rvalid_i && dir_q && rem_q != '0) ||
                       ((state_q == S_RX_PUT) && mem_gnt_i && rem_after != '0);
   assign pk_cnt_o   = (state_q == S_RX_PUT) ? next_cnt : cur_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q        <= S_IDLE;
         dir_q          <= 1'b0;
         rem_q          <= '0;
         off_q          <= '0;
         base_q         <= '0;
         ptr_q          <= '0;
         status_q       <= '0;
         sizes_q        <= '0;
         tx_done_o      <= 1'b0;
         rx_done_o      <= 1'b0;
         desc_unavail_o <= 1'b0;
      end else begin
         tx_done_o      <= 1'b0;
         rx_done_o      <= 1'b0;
         desc_unavail_o <= 1'b0;
         unique case (state_q)
            S_IDLE: if (start_i) begin
               dir_q   <= dir_i;
               rem_q   <= len_i;
               off_q   <= '0;
               base_q  <= desc_base_i;
               state_q <= S_DSC0_REQ;
            end
            S_DSC0_REQ: if (mem_gnt_i) state_q <= S_DSC0_WAIT;
            S_DSC0_WAIT: if (mem_rvalid_i) begin
               status_q <= mem_rdata_i[31:0];
               sizes_q  <= mem_rdata_i[63:32];
               if (!mem_rdata_i[OWN_BIT]) begin
                  desc_unavail_o <= 1'b1;
                  state_q        <= S_IDLE;
               end else begin
                  state_q <= S_DSC1_REQ;
               end
            end
            S_DSC1_REQ: if (mem_gnt_i) state_q <= S_DSC1_WAIT;
            S_DSC1_WAIT: if (mem_rvalid_i) begin
               ptr_q <= mem_rdata_i[ADDR_W-1:0];
               if (rem_q == '0)  state_q <= S_WB_REQ;
               else if (!dir_q)  state_q <= S_TX_REQ;
               else              state_q <= S_RX_FILL;
            end
            S_TX_REQ: if (mem_gnt_i) state_q <= S_TX_WAIT;
            S_TX_WAIT: if (mem_rvalid_i) begin
               rem_q   <= rem_after;
               off_q   <= off_q + OFF_W'(BEAT_BYTES);
               state_q <= S_TX_DRAIN;
            end
            S_TX_DRAIN: if (ser_empty_i) begin
               state_q <= (rem_q == '0) ? S_WB_REQ : S_TX_REQ;
            end
            S_RX_FILL: if (pk_full_i) state_q <= S_RX_PUT;
            S_RX_PUT: if (mem_gnt_i) begin
               rem_q   <= rem_after;
               off_q   <= off_q + OFF_W'(BEAT_BYTES);
               state_q <= (rem_after == '0) ? S_WB_REQ : S_RX_FILL;
            end
            S_WB_REQ: if (mem_gnt_i) begin
               tx_done_o <= !dir_q;
               rx_done_o <= dir_q;
               state_q   <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R8: an ungranted request keeps every field
   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o)));

   // R7: completion and unavailable flags are mutually exclusive
   assert_evt_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_done_o, rx_done_o, desc_unavail_o}));

   // R6: a completion flag follows a granted write to the descriptor
   assert_done_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done_o || rx_done_o) |-> ($past(mem_req_o && mem_we_o && mem_gnt_i) &&
                                    $past(mem_addr_o) == base_q));

   // R3: unavailable only after a status word with ownership clear
   assert_unavail_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_unavail_o |-> ($past(mem_rvalid_i) && !$past(mem_rdata_i[OWN_BIT]) && !mem_req_o));
endmodule

// File: rtl/nand_dma_engine.sv
module nand_dma_engine #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 12,
   parameter int BEAT_BYTES = 8,
   localparam int DATA_W = 8 * BEAT_BYTES,
   localparam int CNT_W  = $clog2(BEAT_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] desc_base_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              tx_valid_o,
   output logic [7:0]        tx_data_o,
   input  logic              tx_ready_i,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_data_i,
   output logic              rx_ready_o,
   output logic              tx_done_o,
   output logic              rx_done_o,
   output logic              desc_unavail_o
);
   if (BEAT_BYTES != 8) begin : g_bad_beat
      $error("descriptor layout needs a 64-bit memory beat");
   end
   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 16..32");
   end
   if (LEN_W < 4 || LEN_W >= ADDR_W) begin : g_bad_len
      $error("LEN_W must be at least 4 and below ADDR_W");
   end

   logic              ser_load;
   logic [CNT_W-1:0]  ser_cnt;
   logic              ser_empty;
   logic              pk_arm;
   logic [CNT_W-1:0]  pk_cnt;
   logic              pk_full;
   logic [DATA_W-1:0] pk_beat;

   nand_dma_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .dir_i          (dir_i),
      .len_i          (len_i),
      .desc_base_i    (desc_base_i),
      .mem_req_o      (mem_req_o),
      .mem_we_o       (mem_we_o),
      .mem_addr_o     (mem_addr_o),
      .mem_wdata_o    (mem_wdata_o),
      .mem_gnt_i      (mem_gnt_i),
      .mem_rvalid_i   (mem_rvalid_i),
      .mem_rdata_i    (mem_rdata_i),
      .ser_load_o     (ser_load),
      .ser_cnt_o      (ser_cnt),
      .ser_empty_i    (ser_empty),
      .pk_arm_o       (pk_arm),
      .pk_cnt_o       (pk_cnt),
      .pk_full_i      (pk_full),
      .pk_beat_i      (pk_beat),
      .tx_done_o      (tx_done_o),
      .rx_done_o      (rx_done_o),
      .desc_unavail_o (desc_unavail_o)
   );

   nand_dma_txser #(.BEAT_BYTES(BEAT_BYTES)) u_txser (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ser_load),
      .beat_i     (mem_rdata_i),
      .cnt_i      (ser_cnt),
      .empty_o    (ser_empty),
      .tx_valid_o (tx_valid_o),
      .tx_data_o  (tx_data_o),
      .tx_ready_i (tx_ready_i)
   );

   nand_dma_rxpack #(.BEAT_BYTES(BEAT_BYTES)) u_rxpack (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (pk_arm),
      .cnt_i      (pk_cnt),
      .full_o     (pk_full),
      .beat_o     (pk_beat),
      .rx_valid_i (rx_valid_i),
      .rx_data_i  (rx_data_i),
      .rx_ready_o (rx_ready_o)
   );
endmodule

// File: tb/nand_dma_engine_tb_top.sv
module nand_dma_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        dir_i = 1'b0;
   logic [11:0] len_i = '0;
   logic [31:0] desc_base_i = '0;
   logic        mem_req_o, mem_we_o;
   logic [31:0] mem_addr_o;
   logic [63:0] mem_wdata_o;
   logic        mem_gnt_i = 1'b0;
   logic        mem_rvalid_i = 1'b0;
   logic [63:0] mem_rdata_i = '0;
   logic        tx_valid_o;
   logic [7:0]  tx_data_o;
   logic        tx_ready_i = 1'b0;
   logic        rx_valid_i = 1'b0;
   logic [7:0]  rx_data_i = '0;
   logic        rx_ready_o;
   logic        tx_done_o, rx_done_o, desc_unavail_o;

   always #4 clk = ~clk;

   nand_dma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i), .len_i(len_i),
      .desc_base_i(desc_base_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
      .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .tx_valid_o(tx_valid_o),
      .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i), .rx_valid_i(rx_valid_i),
      .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o), .tx_done_o(tx_done_o),
      .rx_done_o(rx_done_o), .desc_unavail_o(desc_unavail_o)
   );

   typedef struct {
      bit          we;
      logic [31:0] addr;
      logic [63:0] data;
      string       tag;
   } txn_t;

   logic [63:0] mem [0:255];
   txn_t        exp_q [$];
   logic [7:0]  exp_tx [$];
   logic [7:0]  rx_src [$];

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int n_txd = 0, n_rxd = 0, n_unav = 0;
   int keep_mem = 0, keep_tx = 0;
   bit start_req = 0, pend_dir = 0, chain_armed = 0, noise_en = 0;
   logic [11:0] pend_len;
   logic [31:0] pend_base;
   bit chain_dir;
   logic [11:0] chain_len;
   logic [31:0] chain_base;
   int chain_keep_mem, chain_keep_tx;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // memory, stream and event monitor: all driving happens at the falling edge
   initial begin : monitor
      bit          rx_fire_prev = 0;
      bit          rd_pend = 0;
      int          rd_wait = 0;
      logic [63:0] rd_data = '0;
      bit          hold_prev = 0;
      logic [31:0] h_addr = '0;
      logic        h_we = 0;
      logic [63:0] h_wd = '0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
         end
         // receive stream source
         if (rx_fire_prev) void'(rx_src.pop_front());
         rx_valid_i = (rx_src.size() > 0) && ($urandom % 4 != 0);
         rx_data_i  = (rx_src.size() > 0) ? rx_src[0] : 8'h00;
         rx_fire_prev = rx_valid_i && rx_ready_o;
         // read data return
         mem_rvalid_i = 1'b0;
         if (rd_pend) begin
            if (rd_wait == 0) begin
               mem_rvalid_i = 1'b1;
               mem_rdata_i  = rd_data;
               rd_pend = 0;
            end else rd_wait--;
         end
         // R8 request hold seen at the port
         if (hold_prev)
            chk(mem_req_o && mem_addr_o == h_addr && mem_we_o == h_we && mem_wdata_o == h_wd,
                "R8 request held", {31'b0, mem_req_o, mem_addr_o}, {32'b1, h_addr});
         mem_gnt_i = ($urandom % 3 != 0);
         hold_prev = mem_req_o && !mem_gnt_i;
         h_addr = mem_addr_o; h_we = mem_we_o; h_wd = mem_wdata_o;
         if (mem_req_o && mem_gnt_i) begin
            if (exp_q.size() == 0) begin
               chk(0, "R3 unexpected memory access", {31'b0, mem_we_o, mem_addr_o}, 64'h0);
            end else begin
               txn_t e;
               e = exp_q.pop_front();
               chk(mem_we_o == e.we && mem_addr_o == e.addr, e.tag,
                   {31'b0, mem_we_o, mem_addr_o}, {31'b0, e.we, e.addr});
               if (e.we) chk(mem_wdata_o == e.data, e.tag, mem_wdata_o, e.data);
            end
            if (mem_we_o) mem[mem_addr_o[10:3]] = mem_wdata_o;
            else begin
               rd_pend = 1;
               rd_wait = $urandom % 3;
               rd_data = mem[mem_addr_o[10:3]];
            end
         end
         // transmit stream sink
         tx_ready_i = ($urandom % 4 != 0);
         if (tx_ready_i && tx_valid_o) begin
            if (exp_tx.size() == 0) chk(0, "R4 extra transmit byte", {56'b0, tx_data_o}, 64'h0);
            else begin
               logic [7:0] eb;
               eb = exp_tx.pop_front();
               chk(tx_data_o == eb, "R4 transmit byte", {56'b0, tx_data_o}, {56'b0, eb});
            end
         end
         // events
         if (tx_done_o || rx_done_o) begin
            chk(exp_q.size() == keep_mem, "R6 accesses finished before completion",
                exp_q.size(), keep_mem);
            chk(exp_tx.size() == keep_tx && rx_src.size() == 0, "R6 streams finished before completion",
                exp_tx.size() + rx_src.size(), keep_tx);
         end
         if (tx_done_o) n_txd++;
         if (rx_done_o) n_rxd++;
         if (desc_unavail_o) n_unav++;
         // start control
         start_i = 1'b0;
         if (start_req) begin
            start_i = 1'b1; dir_i = pend_dir; len_i = pend_len; desc_base_i = pend_base;
            start_req = 0;
         end else if (chain_armed && (tx_done_o || rx_done_o)) begin
            // R9: a start in the completion cycle is taken
            start_i = 1'b1; dir_i = chain_dir; len_i = chain_len; desc_base_i = chain_base;
            keep_mem = chain_keep_mem; keep_tx = chain_keep_tx;
            chain_armed = 0;
         end else if (noise_en && (cyc % 5 == 0) && exp_q.size() > 0) begin
            start_i = 1'b1; dir_i = ~dir_i; len_i = 12'd7; desc_base_i = 32'h0000_0700;
         end
      end
   end

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed * 17 + i * 29 + 3) & 255);
   endfunction

   // lays out a descriptor and buffer, pushes every expected item
   task automatic setup_xfer(input bit dir, input int len, input bit own, input logic [31:0] base,
                             input logic [31:0] ptr, input int seed);
      logic [31:0] status, sizes;
      int nb;
      status = {own, 27'b0, 4'b1100};
      sizes  = 32'(((len + 7) / 8) * 8) & 32'hFFF;
      nb     = (len + 7) / 8;
      mem[base[10:3]]     = {sizes, status};
      mem[base[10:3] + 1] = {32'hDEAD_BEEF, ptr};
      exp_q.push_back('{0, base, 64'h0, "R2 status word read"});
      if (!own) return;
      exp_q.push_back('{0, base + 8, 64'h0, "R2 pointer word read"});
      for (int b = 0; b < nb; b++) begin
         logic [63:0] w;
         w = '0;
         for (int k = 0; k < 8; k++) w[8*k +: 8] = pat(seed, 8*b + k);
         if (!dir) begin
            mem[ptr[10:3] + 8'(b)] = w;
            exp_q.push_back('{0, ptr + 32'(8*b), 64'h0, "R4 buffer beat read"});
            for (int k = 0; k < 8; k++) if (8*b + k < len) exp_tx.push_back(w[8*k +: 8]);
         end else begin
            mem[ptr[10:3] + 8'(b)] = 64'hFFFF_FFFF_FFFF_FFFF;
            for (int k = 0; k < 8; k++) begin
               if (8*b + k < len) rx_src.push_back(w[8*k +: 8]);
               else w[8*k +: 8] = 8'h00;
            end
            exp_q.push_back('{1, ptr + 32'(8*b), w, "R5 buffer beat write"});
         end
      end
      exp_q.push_back('{1, base, {sizes, status & 32'h7FFF_FFFF}, "R6 status write-back"});
   endtask

   task automatic wait_events(input int total);
      while (n_txd + n_rxd + n_unav < total) @(posedge clk);
      repeat (12) @(posedge clk);
   endtask

   task automatic run_one(input bit dir, input int len, input bit own, input logic [31:0] base,
                          input logic [31:0] ptr, input int seed);
      int t0, r0, u0;
      t0 = n_txd; r0 = n_rxd; u0 = n_unav;
      @(posedge clk);
      keep_mem = 0; keep_tx = 0;
      setup_xfer(dir, len, own, base, ptr, seed);
      pend_dir = dir; pend_len = 12'(len); pend_base = base; start_req = 1;
      wait_events(t0 + r0 + u0 + 1);
      chk(exp_q.size() == 0, "R2 all expected accesses made", exp_q.size(), 0);
      if (!own) begin
         chk(n_unav == u0 + 1 && n_txd == t0 && n_rxd == r0, "R3 unavailable pulse only",
             n_unav - u0, 1);
         chk(mem[base[10:3]][31] == 1'b0 && exp_tx.size() == 0, "R3 descriptor untouched",
             mem[base[10:3]], 64'h0);
      end else begin
         chk((dir ? n_rxd - r0 : n_txd - t0) == 1 && (dir ? n_txd - t0 : n_rxd - r0) == 0 &&
             n_unav == u0, "R7 one completion pulse of the right kind",
             dir ? n_rxd - r0 : n_txd - t0, 1);
         chk(mem[base[10:3]][31] == 1'b0 && mem[base[10:3]][3:2] == 2'b11,
             "R6 ownership returned", mem[base[10:3]], 64'h0);
      end
   endtask

   initial begin : main
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!mem_req_o, "R1 mem_req_o in reset", mem_req_o, 0);
      chk(!tx_valid_o && !rx_ready_o, "R1 streams idle in reset", {tx_valid_o, rx_ready_o}, 0);
      chk(!tx_done_o && !rx_done_o && !desc_unavail_o, "R1 flags low in reset",
          {tx_done_o, rx_done_o, desc_unavail_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!mem_req_o && !tx_valid_o && !rx_ready_o, "R1 idle after reset",
          {mem_req_o, tx_valid_o, rx_ready_o}, 0);

      run_one(0, 13, 1, 32'h0000_0040, 32'h0000_0100, 1);  // R4 two beats, five-byte tail
      run_one(1, 11, 1, 32'h0000_0060, 32'h0000_0200, 2);  // R5 padding written as zero
      run_one(0, 8, 1, 32'h0000_0080, 32'h0000_0300, 3);   // R4 exact single beat
      run_one(1, 1, 1, 32'h0000_00A0, 32'h0000_0380, 4);   // R5 single byte
      run_one(0, 21, 0, 32'h0000_00C0, 32'h0000_0400, 5);  // R3 descriptor not owned
      run_one(1, 24, 1, 32'h0000_00E0, 32'h0000_0480, 6);  // R5 three full beats

      // R9 starts during a transfer are ignored
      noise_en = 1;
      run_one(0, 19, 1, 32'h0000_0020, 32'h0000_0500, 7);
      noise_en = 0;
      run_one(1, 5, 1, 32'h0000_0028, 32'h0000_0580, 8);

      // R9 chained start in the completion cycle
      begin
         int q0, t0, m0, tx0;
         @(posedge clk);
         q0 = n_txd + n_rxd + n_unav; t0 = n_txd;
         keep_mem = 0; keep_tx = 0;
         setup_xfer(1, 20, 1, 32'h0000_0600, 32'h0000_0640, 9);
         m0 = exp_q.size(); tx0 = exp_tx.size();
         setup_xfer(0, 3, 1, 32'h0000_0680, 32'h0000_06C0, 10);
         chain_keep_mem = 0; chain_keep_tx = 0;
         keep_mem = exp_q.size() - m0; keep_tx = exp_tx.size() - tx0;
         chain_dir = 0; chain_len = 12'd3; chain_base = 32'h0000_0680; chain_armed = 1;
         pend_dir = 1; pend_len = 12'd20; pend_base = 32'h0000_0600; start_req = 1;
         wait_events(q0 + 2);
         chk(exp_q.size() == 0 && exp_tx.size() == 0, "R9 chained transfer completed",
             exp_q.size() + exp_tx.size(), 0);
         chk(n_txd == t0 + 1 && !chain_armed, "R9 chained completion pulse", n_txd - t0, 1);
      end

      finish_run();
   end
endmodule